// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken. Two component predictors run side by side. The first indexes a table of 2-bit saturating counters with a shift register that holds the outcomes of the most recent branches. The second is a two-level predictor. A per-branch history table, indexed by the PC, records the recent outcomes of that branch, and that pattern selects a 3-bit saturating counter. A PC-indexed table of 2-bit selector counters decides, per branch, which of the two components supplies the final answer.

A lookup is combinational. The front end drives a PC and, in the same cycle, reads the final prediction together with both component predictions. When the branch resolves, the back end presents one update. The update carries the PC, the real outcome and the two component predictions that were read at lookup. On the clock edge it trains both components, shifts the outcome into the global history and into that branch's local history, and trains the selector. The default table sizes are small. Setting the index widths to 12, 12, 10 and 10 gives the full-size configuration. Histories are updated only at resolution; no speculative history or target address is kept.

Top module: `tourney_predictor`

## Requirements
- R1: `pred_final` equals `pred_global` when the selector counter at `lk_pc[CHO_IDX_W+1:2]` has its MSB set (value 2 or 3), and equals `pred_local` otherwise; lookups are combinational from the current table state.
- R2: After a synchronous active-low reset, every selector counter holds 2 (weakly prefers global), every global counter holds 1, every local pattern counter holds 3, and both histories are zero, so all three predictions read 0 for any PC.
- R3: The global prediction is the MSB of the 2-bit counter indexed by the global history register. On an update, that counter is incremented when taken and decremented when not taken, saturating at 0 and 3. The counter trained is the one at the history value held before the update's shift.
- R4: On each update the global history becomes `{ghr[GHIST_W-2:0], upd_taken}`, with the newest outcome in bit 0.
- R5: The local prediction is 1 when the 3-bit counter, indexed by the local history read at `pc[LHT_IDX_W+1:2]`, is 4 or more. On an update, the counter at the entry's pre-update history moves up on taken and down on not taken, saturating at 0 and 7.
- R6: On an update, the local history entry at `upd_pc[LHT_IDX_W+1:2]` becomes `{entry[LHIST_W-2:0], upd_taken}`.
- R7: When `upd_pred_global` differs from `upd_pred_local`, the selector counter at `upd_pc[CHO_IDX_W+1:2]` moves up by one if the global prediction equalled `upd_taken`, and down by one otherwise, saturating at 0 and 3.
- R8: When `upd_pred_global` equals `upd_pred_local`, whether both were right or both wrong, the selector counter is left unchanged.
- R9: While `upd_valid` is 0, no table or history changes, so the predictions for any PC stay the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_pc | input | PC_W | PC of the branch being looked up |
| pred_final | output | 1 | Chosen direction, 1 = taken |
| pred_global | output | 1 | Global-history component prediction |
| pred_local | output | 1 | Local-history component prediction |
| upd_valid | input | 1 | An update is applied at this clock edge |
| upd_pc | input | PC_W | PC of the resolved branch |
| upd_taken | input | 1 | Real outcome, 1 = taken |
| upd_pred_global | input | 1 | Global prediction read at lookup |
| upd_pred_local | input | 1 | Local prediction read at lookup |

## Verification
The checker watches several behaviours on every cycle. It checks the shift of the global history on an update and its hold when no update is applied. It checks that the selector is written exactly when the supplied component predictions disagree. It also checks that the final prediction follows the components whenever they agree. The training of the saturating counters, the per-branch local histories and the selector's effect on which component wins can only be shown by the bench. It does this by running loop-style, alternating and biased branch streams, forced disagreements and idle stretches, and comparing every lookup against an independent model.

// File: rtl/tp_pkg.sv
// Shared definitions for the tournament predictor.
// Assumes: counters are trained by one step per update.
package tp_pkg;
    // Direction in which a saturating counter is trained
    typedef enum logic {
        TRAIN_DOWN = 1'b0,
        TRAIN_UP   = 1'b1
    } train_dir_e;

    // Word offset: instruction PCs are 4-byte aligned
    localparam int PC_OFS = 2;
endpackage

// File: rtl/tp_sat_table.sv
// Table of saturating counters with one combinational read port and one
// read-modify-write training port.
// Assumes: at most one training write per cycle; reset loads RST_VAL everywhere.
module tp_sat_table
    import tp_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int CTR_W = 2,
    parameter logic [CTR_W-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [CTR_W-1:0] rd_ctr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  train_dir_e       wr_dir
);
    localparam int DEPTH = 1 << IDX_W;
    localparam logic [CTR_W-1:0] CTR_MAX = '1;
    localparam logic [CTR_W-1:0] CTR_ONE = CTR_W'(1);

    logic [CTR_W-1:0] ctr_q [DEPTH];
    logic [CTR_W-1:0] cur_ctr;
    logic [CTR_W-1:0] nxt_ctr;

    // Lookup read
    assign rd_ctr = ctr_q[rd_idx];

    // Saturating step of the entry being trained
    always_comb begin
        cur_ctr = ctr_q[wr_idx];
        nxt_ctr = cur_ctr;
        if (wr_dir == TRAIN_UP) begin
            if (cur_ctr != CTR_MAX) nxt_ctr = cur_ctr + CTR_ONE;
        end else begin
            if (cur_ctr != '0) nxt_ctr = cur_ctr - CTR_ONE;
        end
    end

    // Counter storage: reset fill, then one trained entry per update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) ctr_q[i] <= RST_VAL;
        end else if (wr_en) begin
            ctr_q[wr_idx] <= nxt_ctr;
        end
    end
endmodule

// File: rtl/tp_global_comp.sv
// Global-history component: a shift register of recent outcomes indexes a
// table of 2-bit counters; the counter MSB is the prediction.
// Assumes: history is updated only at resolution, so the lookup index and
// the training index are the same register value.
module tp_global_comp
    import tp_pkg::*;
#(
    parameter int GHIST_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic               pred,
    input  logic               upd_en,
    input  logic               upd_taken,
    output logic [GHIST_W-1:0] ghr_o
);
    logic [GHIST_W-1:0] ghr_q;
    logic [1:0]         ctr;
    train_dir_e         dir;

    assign dir   = upd_taken ? TRAIN_UP : TRAIN_DOWN;
    assign pred  = ctr[1];
    assign ghr_o = ghr_q;

    tp_sat_table #(
        .IDX_W  (GHIST_W),
        .CTR_W  (2),
        .RST_VAL(2'd1)
    ) u_tbl (
        .clk   (clk),
        .rst_n (rst_n),
        .rd_idx(ghr_q),
        .rd_ctr(ctr),
        .wr_en (upd_en),
        .wr_idx(ghr_q),
        .wr_dir(dir)
    );

    // Global history: newest outcome enters at bit 0
    always_ff @(posedge clk) begin
        if (!rst_n)      ghr_q <= '0;
        else if (upd_en) ghr_q <= {ghr_q[GHIST_W-2:0], upd_taken};
    end
endmodule

// File: rtl/tp_local_comp.sv
// Two-level local component: a PC-indexed table of per-branch histories;
// the selected history indexes a table of 3-bit counters, and a value of
// 4 or more predicts taken.
// Assumes: index fields are already extracted from the PC by the caller.
module tp_local_comp
    import tp_pkg::*;
#(
    parameter int LHT_IDX_W = 6,
    parameter int LHIST_W   = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [LHT_IDX_W-1:0] lk_idx,
    output logic                 pred,
    input  logic                 upd_en,
    input  logic [LHT_IDX_W-1:0] upd_idx,
    input  logic                 upd_taken
);
    localparam int LHT_DEPTH = 1 << LHT_IDX_W;

    logic [LHIST_W-1:0] hist_q [LHT_DEPTH];
    logic [LHIST_W-1:0] lk_hist;
    logic [LHIST_W-1:0] upd_hist;
    logic [2:0]         ctr;
    train_dir_e         dir;

    assign lk_hist  = hist_q[lk_idx];
    assign upd_hist = hist_q[upd_idx];
    assign dir      = upd_taken ? TRAIN_UP : TRAIN_DOWN;
    assign pred     = ctr[2];

    tp_sat_table #(
        .IDX_W  (LHIST_W),
        .CTR_W  (3),
        .RST_VAL(3'd3)
    ) u_pat (
        .clk   (clk),
        .rst_n (rst_n),
        .rd_idx(lk_hist),
        .rd_ctr(ctr),
        .wr_en (upd_en),
        .wr_idx(upd_hist),
        .wr_dir(dir)
    );

    // Per-branch history: shift the outcome into the updated entry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LHT_DEPTH; i++) hist_q[i] <= '0;
        end else if (upd_en) begin
            hist_q[upd_idx] <= {upd_hist[LHIST_W-2:0], upd_taken};
        end
    end
endmodule

// File: rtl/tourney_predictor.sv
// Tournament direction predictor: a global-history component and a local
// two-level component run side by side, and a PC-indexed table of 2-bit
// selector counters (MSB set = use global) picks one per branch.
// Assumes: lookups are combinational; one resolved update per cycle at most;
// the caller returns the component predictions it saw at lookup.
module tourney_predictor
    import tp_pkg::*;
#(
    parameter int PC_W      = 32,
    parameter int CHO_IDX_W = 8,
    parameter int GHIST_W   = 8,
    parameter int LHT_IDX_W = 6,
    parameter int LHIST_W   = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] lk_pc,
    output logic            pred_final,
    output logic            pred_global,
    output logic            pred_local,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken,
    input  logic            upd_pred_global,
    input  logic            upd_pred_local
);
    logic [CHO_IDX_W-1:0] lk_cho_idx;
    logic [CHO_IDX_W-1:0] upd_cho_idx;
    logic [LHT_IDX_W-1:0] lk_lht_idx;
    logic [LHT_IDX_W-1:0] upd_lht_idx;
    logic [1:0]           cho_ctr;
    logic                 cho_we;
    train_dir_e           cho_dir;
    logic [GHIST_W-1:0]   ghr_q;
    logic                 unused_pc_bits;

    // Index fields taken just above the word offset
    assign lk_cho_idx     = lk_pc[PC_OFS +: CHO_IDX_W];
    assign upd_cho_idx    = upd_pc[PC_OFS +: CHO_IDX_W];
    assign lk_lht_idx     = lk_pc[PC_OFS +: LHT_IDX_W];
    assign upd_lht_idx    = upd_pc[PC_OFS +: LHT_IDX_W];
    assign unused_pc_bits = ^{lk_pc, upd_pc};

    // Selector training: only on disagreement, toward the correct side
    assign cho_we  = upd_valid && (upd_pred_global != upd_pred_local);
    assign cho_dir = (upd_pred_global == upd_taken) ? TRAIN_UP : TRAIN_DOWN;

    tp_sat_table #(
        .IDX_W  (CHO_IDX_W),
        .CTR_W  (2),
        .RST_VAL(2'd2)
    ) u_chooser (
        .clk   (clk),
        .rst_n (rst_n),
        .rd_idx(lk_cho_idx),
        .rd_ctr(cho_ctr),
        .wr_en (cho_we),
        .wr_idx(upd_cho_idx),
        .wr_dir(cho_dir)
    );

    tp_global_comp #(
        .GHIST_W(GHIST_W)
    ) u_glob (
        .clk      (clk),
        .rst_n    (rst_n),
        .pred     (pred_global),
        .upd_en   (upd_valid),
        .upd_taken(upd_taken),
        .ghr_o    (ghr_q)
    );

    tp_local_comp #(
        .LHT_IDX_W(LHT_IDX_W),
        .LHIST_W  (LHIST_W)
    ) u_loc (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_idx   (lk_lht_idx),
        .pred     (pred_local),
        .upd_en   (upd_valid),
        .upd_idx  (upd_lht_idx),
        .upd_taken(upd_taken)
    );

    // Final choice by the selector MSB
    assign pred_final = cho_ctr[1] ? pred_global : pred_local;
endmodule

// File: rtl/tp_checker.sv
// Cycle-level properties of the tournament predictor, bound to the top.
// Assumes: reset is held low from time zero.
module tp_checker #(
    parameter int GHIST_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               upd_valid,
    input logic               upd_taken,
    input logic               upd_pred_global,
    input logic               upd_pred_local,
    input logic               pred_final,
    input logic               pred_global,
    input logic               pred_local,
    input logic [GHIST_W-1:0] ghr,
    input logic               cho_we
);
    // R1
    agree_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_global == pred_local) |-> (pred_final == pred_global));

    // R4
    ghr_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> (ghr == {$past(ghr[GHIST_W-2:0]), $past(upd_taken)}));

    // R9
    ghr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> $stable(ghr));

    // R8
    chooser_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && (upd_pred_global == upd_pred_local)) |-> !cho_we);

    // R7
    chooser_train_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && (upd_pred_global != upd_pred_local)) |-> cho_we);

    // R9
    chooser_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |-> !cho_we);
endmodule

bind tourney_predictor tp_checker #(
    .GHIST_W(GHIST_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .upd_valid      (upd_valid),
    .upd_taken      (upd_taken),
    .upd_pred_global(upd_pred_global),
    .upd_pred_local (upd_pred_local),
    .pred_final     (pred_final),
    .pred_global    (pred_global),
    .pred_local     (pred_local),
    .ghr            (ghr_q),
    .cho_we         (cho_we)
);

// File: tb/tb_tourney_predictor.sv
`timescale 1ns/1ps
module tb_tourney_predictor;
    localparam int PC_W = 32;
    localparam int CI = 8;
    localparam int GH = 8;
    localparam int LI = 6;
    localparam int LH = 6;
    localparam int NVEC = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [PC_W-1:0] lk_pc = '0;
    logic pred_final, pred_global, pred_local;
    logic upd_valid = 1'b0;
    logic [PC_W-1:0] upd_pc = '0;
    logic upd_taken = 1'b0;
    logic upd_pred_global = 1'b0;
    logic upd_pred_local = 1'b0;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // Independent model state built from the requirements
    int m_cho [1 << CI];
    int m_gt  [1 << GH];
    int m_lt  [1 << LH];
    logic [LH-1:0] m_lht [1 << LI];
    logic [GH-1:0] m_ghr;

    tourney_predictor #(
        .PC_W(PC_W), .CHO_IDX_W(CI), .GHIST_W(GH), .LHT_IDX_W(LI), .LHIST_W(LH)
    ) dut (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc),
        .pred_final(pred_final), .pred_global(pred_global), .pred_local(pred_local),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
        .upd_pred_global(upd_pred_global), .upd_pred_local(upd_pred_local)
    );

    always #10 clk = ~clk;

    // Stimulus vectors: {pc, taken, repeat count}
    localparam logic [40:0] VEC [NVEC] = '{
        {32'h0000_0100, 1'b1, 8'd7}, {32'h0000_0100, 1'b0, 8'd1},
        {32'h0000_0100, 1'b1, 8'd7}, {32'h0000_0100, 1'b0, 8'd1},
        {32'h0000_0204, 1'b1, 8'd1}, {32'h0000_0204, 1'b0, 8'd1},
        {32'h0000_0204, 1'b1, 8'd1}, {32'h0000_0204, 1'b0, 8'd1},
        {32'h0000_0308, 1'b1, 8'd12}, {32'h0000_040C, 1'b0, 8'd9},
        {32'h0000_0100, 1'b1, 8'd20}, {32'h0000_0510, 1'b0, 8'd10},
        {32'h0000_0204, 1'b1, 8'd1}, {32'h0000_0204, 1'b0, 8'd1},
        {32'h0000_0100, 1'b1, 8'd7}, {32'h0000_0100, 1'b0, 8'd1}
    };

    task automatic check(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b time=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic int sat(input int v, input logic up, input int mx);
        if (up) return (v < mx) ? v + 1 : v;
        return (v > 0) ? v - 1 : v;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < (1 << CI); i++) m_cho[i] = 2;
        for (int i = 0; i < (1 << GH); i++) m_gt[i] = 1;
        for (int i = 0; i < (1 << LH); i++) m_lt[i] = 3;
        for (int i = 0; i < (1 << LI); i++) m_lht[i] = '0;
        m_ghr = '0;
    endtask

    // One lookup with checks, then optionally one update at the next edge.
    // ovr=1 replaces the returned component predictions with og/ol.
    task automatic step(input logic [PC_W-1:0] pc, input logic taken, input logic en,
                        input logic ovr, input logic og, input logic ol, input string ctx);
        logic eg, el, ef, sg, sl;
        int ci, li;
        @(negedge clk);
        lk_pc = pc;
        #1;
        ci = int'(pc[2 +: CI]);
        li = int'(pc[2 +: LI]);
        eg = (m_gt[m_ghr] >= 2);
        el = (m_lt[m_lht[li]] >= 4);
        ef = (m_cho[ci] >= 2) ? eg : el;
        check({ctx, " R3/R4 global"}, pred_global, eg);
        check({ctx, " R5/R6 local"}, pred_local, el);
        check({ctx, " R1/R7/R8 final"}, pred_final, ef);
        sg = ovr ? og : eg;
        sl = ovr ? ol : el;
        upd_valid = en;
        upd_pc = pc;
        upd_taken = taken;
        upd_pred_global = sg;
        upd_pred_local = sl;
        @(posedge clk);
        #1;
        upd_valid = 1'b0;
        if (en) begin
            if (sg != sl) m_cho[ci] = sat(m_cho[ci], sg == taken, 3);
            m_gt[m_ghr] = sat(m_gt[m_ghr], taken, 3);
            m_ghr = {m_ghr[GH-2:0], taken};
            m_lt[m_lht[li]] = sat(m_lt[m_lht[li]], taken, 7);
            m_lht[li] = {m_lht[li][LH-2:0], taken};
        end
    endtask

    initial begin
        #(20ns * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog all-requirements actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: reset state, all predictions 0 for several PCs
        foreach (VEC[k]) begin
            @(negedge clk);
            lk_pc = VEC[k][40:9];
            #1;
            check("R2 reset final", pred_final, 1'b0);
            check("R2 reset global", pred_global, 1'b0);
            check("R2 reset local", pred_local, 1'b0);
        end

        // Main vector walk against the model
        for (int v = 0; v < NVEC; v++) begin
            for (int r = 0; r < int'(VEC[v][7:0]); r++)
                step(VEC[v][40:9], VEC[v][8], 1'b1, 1'b0, 1'b0, 1'b0, "vec");
        end

        // R9: idle cycles leave every prediction unchanged
        for (int i = 0; i < 6; i++)
            step(32'h0000_0100 + 32'(i * 4), 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R9 idle");

        // R7: forced disagreements with local right drive selector to local
        for (int i = 0; i < 5; i++)
            step(32'h0000_0620, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, "R7 toward-local");
        // R8: agreement (both right, then both wrong) leaves selector alone
        for (int i = 0; i < 3; i++)
            step(32'h0000_0620, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, "R8 both-right");
        for (int i = 0; i < 3; i++)
            step(32'h0000_0620, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, "R8 both-wrong");
        // R7: forced disagreements with global right saturate toward global
        for (int i = 0; i < 5; i++)
            step(32'h0000_0620, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, "R7 toward-global");

        // R3/R5: long taken run saturates both component counters
        for (int i = 0; i < 24; i++)
            step(32'h0000_0730, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R3/R5 saturate");
        step(32'h0000_0730, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R3/R5 saturated");

        // R2: reset again mid-run clears everything
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        lk_pc = 32'h0000_0730;
        #1;
        check("R2 re-reset final", pred_final, 1'b0);
        check("R2 re-reset global", pred_global, 1'b0);
        check("R2 re-reset local", pred_local, 1'b0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule